// File: doc/BRIEF.md
# NMI-aware pending interrupt arbiter

This block picks, for one CPU interface, the single most urgent interrupt out of a vector of interrupt lines. Each line carries a pending bit, an enable bit, an 8-bit programmed priority, a group bit (1 = non-secure) and a non-maskable flag. A global security-disable input changes how non-maskable lines are ranked. A lower priority value means a more urgent interrupt. A non-maskable line does not use its programmed priority. It is ranked at a fixed level, and it beats ordinary lines at that same level.

Beside the local lines, the arbiter takes one message-signalled candidate. That candidate has its own ID and priority and three enable qualifiers. It is always ranked as an ordinary interrupt, and it is compared after all local lines. The winner's ID, effective priority and non-maskable flag are registered. They appear on the outputs one clock after the inputs are sampled, together with a valid flag.

Top module: `nmi_irq_arbiter`

## Requirements
- R1: Among eligible candidates, a strictly lower effective priority value always wins.
- R2: A non-maskable line ignores its programmed priority. Its effective priority is 0x80 when sec_dis is 0 and its group bit is 1. In every other case its effective priority is 0x00.
- R3: When effective priorities are equal, a non-maskable candidate beats an ordinary one, even an ordinary line with a lower ID.
- R4: When effective priorities are equal and only ordinary lines are involved, the lowest ID wins.
- R5: When effective priorities are equal and the best so far is non-maskable, nothing displaces it. This holds for ordinary candidates, for the message candidate and for other non-maskable lines. So among equal non-maskable lines, the lowest ID wins.
- R6: A line whose pending or enable bit is 0 never takes part in arbitration, whatever its non-maskable flag.
- R7: The message candidate is considered only when msg_lpi_en, msg_glb_en and msg_g1ns_en are all 1 and msg_prio is not 0xFF. It is never reported as non-maskable. On an equal priority with an ordinary local winner, it wins only if msg_id is less than or equal to that winner's ID.
- R8: The outputs are registered. They change on the first rising clock edge after the inputs change. Synchronous reset, or the absence of any eligible candidate, gives win_valid=0, win_id=0, win_prio=0xFF and win_nmi=0.
- R9: An ordinary line programmed to 0xFF still wins when it is the only eligible candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend | input | N | Pending bit per line |
| en | input | N | Enable bit per line |
| nmi | input | N | Non-maskable flag per line |
| grp | input | N | Group bit per line, 1 = non-secure |
| prio_flat | input | 8*N | Programmed priorities, line i in bits [8i+7:8i] |
| sec_dis | input | 1 | Global security-disable control |
| msg_prio | input | 8 | Message candidate priority |
| msg_id | input | ID_W | Message candidate ID |
| msg_lpi_en | input | 1 | Message candidate local enable |
| msg_glb_en | input | 1 | Message candidate global enable |
| msg_g1ns_en | input | 1 | Non-secure group-1 enable |
| win_valid | output | 1 | A winner exists |
| win_id | output | ID_W | Winner ID |
| win_prio | output | 8 | Winner effective priority |
| win_nmi | output | 1 | Winner is non-maskable |

## Verification
Every result is due on the first rising edge after its inputs change, because there is exactly one register stage between the inputs and the outputs. The bench changes inputs only just after a falling edge and reads the outputs 1 ns after the next rising edge. One latency check also reads the outputs after an input change but before that edge, and expects the previous winner to still be shown. The reset values are read while reset is held across several edges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_IDLE   = 8'hFF;
    localparam prio_t PRIO_NMI_NS = 8'h80;
    localparam prio_t PRIO_NMI_S  = 8'h00;

    // Does a candidate displace the current best?
    // id_le: candidate ID <= best ID, computed by the caller.
    function automatic logic cand_wins(
        input prio_t best_prio,
        input logic  best_nmi,
        input logic  cand_valid,
        input prio_t cand_prio,
        input logic  cand_nmi,
        input logic  id_le
    );
        logic same;
        same = (cand_prio == best_prio);
        if (!cand_valid)
            return 1'b0;
        if (cand_prio < best_prio)
            return 1'b1;
        if (same && !best_nmi && cand_nmi)
            return 1'b1;
        if (same && !best_nmi && !cand_nmi && id_le)
            return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/irq_arb_prep.sv
module irq_arb_prep
    import irq_arb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]        pend,
    input  logic [N-1:0]        en,
    input  logic [N-1:0]        nmi,
    input  logic [N-1:0]        grp,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic                sec_dis,
    output logic [N-1:0]        c_valid,
    output logic [N-1:0]        c_nmi,
    output logic [N*PRIO_W-1:0] c_prio
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic  elig;
        prio_t eff;

        assign elig = pend[i] & en[i];

        always_comb begin
            if (nmi[i])
                eff = (!sec_dis && grp[i]) ? PRIO_NMI_NS : PRIO_NMI_S;
            else
                eff = prio_flat[i*PRIO_W +: PRIO_W];
        end

        assign c_valid[i] = elig;
        assign c_nmi[i]   = elig & nmi[i];
        assign c_prio[i*PRIO_W +: PRIO_W] = elig ? eff : PRIO_IDLE;
    end

endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
    import irq_arb_pkg::*;
#(
    parameter int N    = 32,
    parameter int ID_W = 16
) (
    input  logic [N-1:0]        c_valid,
    input  logic [N-1:0]        c_nmi,
    input  logic [N*PRIO_W-1:0] c_prio,
    output logic                best_valid,
    output logic                best_nmi,
    output prio_t               best_prio,
    output logic [ID_W-1:0]     best_id
);

    localparam int LVL   = (N > 1) ? $clog2(N) : 1;
    localparam int P     = 1 << LVL;
    localparam int NODES = 2 * P - 1;

    typedef struct packed {
        logic            valid;
        logic            nmi;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } cand_t;

    localparam cand_t CAND_NONE = '{valid: 1'b0, nmi: 1'b0, prio: PRIO_IDLE, id: '1};

    cand_t node [NODES];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[P-1+i] = c_valid[i] ?
                cand_t'{valid: 1'b1, nmi: c_nmi[i],
                        prio: c_prio[i*PRIO_W +: PRIO_W], id: ID_W'(i)} :
                CAND_NONE;
        end else begin : g_pad
            assign node[P-1+i] = CAND_NONE;
        end
    end

    // Left subtree always holds the lower IDs, so it plays the
    // "scanned first" role of a sequential search.
    for (genvar k = 0; k < P - 1; k++) begin : g_node
        logic rwin;
        assign rwin = cand_wins(node[2*k+1].prio, node[2*k+1].nmi,
                                node[2*k+2].valid, node[2*k+2].prio,
                                node[2*k+2].nmi,
                                node[2*k+2].id <= node[2*k+1].id);
        assign node[k] = rwin ? node[2*k+2] : node[2*k+1];
    end

    assign best_valid = node[0].valid;
    assign best_nmi   = node[0].nmi;
    assign best_prio  = node[0].prio;
    assign best_id    = node[0].id;

endmodule

// File: rtl/nmi_irq_arbiter.sv
module nmi_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N    = 32,
    parameter int ID_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        pend,
    input  logic [N-1:0]        en,
    input  logic [N-1:0]        nmi,
    input  logic [N-1:0]        grp,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic                sec_dis,
    input  logic [PRIO_W-1:0]   msg_prio,
    input  logic [ID_W-1:0]     msg_id,
    input  logic                msg_lpi_en,
    input  logic                msg_glb_en,
    input  logic                msg_g1ns_en,
    output logic                win_valid,
    output logic [ID_W-1:0]     win_id,
    output logic [PRIO_W-1:0]   win_prio,
    output logic                win_nmi
);

    typedef struct packed {
        logic            valid;
        logic            nmi;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } res_t;

    localparam res_t RES_IDLE = '{valid: 1'b0, nmi: 1'b0, prio: PRIO_IDLE, id: '0};

    logic [N-1:0]        c_valid;
    logic [N-1:0]        c_nmi;
    logic [N*PRIO_W-1:0] c_prio;
    logic                loc_valid;
    logic                loc_nmi;
    prio_t               loc_prio;
    logic [ID_W-1:0]     loc_id;

    irq_arb_prep #(.N(N)) u_prep (
        .pend      (pend),
        .en        (en),
        .nmi       (nmi),
        .grp       (grp),
        .prio_flat (prio_flat),
        .sec_dis   (sec_dis),
        .c_valid   (c_valid),
        .c_nmi     (c_nmi),
        .c_prio    (c_prio)
    );

    irq_arb_tree #(.N(N), .ID_W(ID_W)) u_tree (
        .c_valid    (c_valid),
        .c_nmi      (c_nmi),
        .c_prio     (c_prio),
        .best_valid (loc_valid),
        .best_nmi   (loc_nmi),
        .best_prio  (loc_prio),
        .best_id    (loc_id)
    );

    res_t res_d, res_q;
    logic msg_ok;
    logic msg_wins;

    always_comb begin
        msg_ok   = msg_lpi_en && msg_glb_en && msg_g1ns_en && (msg_prio != PRIO_IDLE);
        msg_wins = cand_wins(loc_prio, loc_nmi, msg_ok, msg_prio, 1'b0,
                             msg_id <= loc_id);
        res_d = RES_IDLE;
        if (msg_wins) begin
            res_d.valid = 1'b1;
            res_d.nmi   = 1'b0;
            res_d.prio  = msg_prio;
            res_d.id    = msg_id;
        end else if (loc_valid) begin
            res_d.valid = 1'b1;
            res_d.nmi   = loc_nmi;
            res_d.prio  = loc_prio;
            res_d.id    = loc_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= RES_IDLE;
        else
            res_q <= res_d;
    end

    assign win_valid = res_q.valid;
    assign win_id    = res_q.id;
    assign win_prio  = res_q.prio;
    assign win_nmi   = res_q.nmi;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int N    = 32,
    parameter int ID_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    pend,
    input logic [N-1:0]    en,
    input logic [N-1:0]    nmi,
    input logic            sec_dis,
    input logic [7:0]      msg_prio,
    input logic [ID_W-1:0] msg_id,
    input logic            msg_lpi_en,
    input logic            msg_glb_en,
    input logic            msg_g1ns_en,
    input logic            win_valid,
    input logic [ID_W-1:0] win_id,
    input logic [7:0]      win_prio,
    input logic            win_nmi
);

    logic msg_ok;
    logic any_loc;
    logic any_nmi;
    assign msg_ok  = msg_lpi_en && msg_glb_en && msg_g1ns_en && (msg_prio != 8'hFF);
    assign any_loc = |(pend & en);
    assign any_nmi = |(pend & en & nmi);

    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (!win_valid && win_prio == 8'hFF && !win_nmi && win_id == '0));

    p_none_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!any_loc && !msg_ok) |=> !win_valid);

    p_nmi_levels_r2: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_nmi) |-> (win_prio == 8'h00 || win_prio == 8'h80));

    p_secdis_level_r2: assert property (@(posedge clk) disable iff (rst)
        sec_dis |=> (!(win_valid && win_nmi) || win_prio == 8'h00));

    p_masked_or_any_r6: assert property (@(posedge clk) disable iff (rst)
        any_loc |=> win_valid);

    p_nmi_pref_r3: assert property (@(posedge clk) disable iff (rst)
        any_nmi |=> (win_valid && (win_nmi || win_prio < 8'h80)));

    p_msg_only_r7: assert property (@(posedge clk) disable iff (rst)
        (!any_loc && msg_ok) |=> (win_valid && !win_nmi &&
                                  win_id == $past(msg_id) &&
                                  win_prio == $past(msg_prio)));

endmodule

bind nmi_irq_arbiter irq_arb_chk #(.N(N), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pend        (pend),
    .en          (en),
    .nmi         (nmi),
    .sec_dis     (sec_dis),
    .msg_prio    (msg_prio),
    .msg_id      (msg_id),
    .msg_lpi_en  (msg_lpi_en),
    .msg_glb_en  (msg_glb_en),
    .msg_g1ns_en (msg_g1ns_en),
    .win_valid   (win_valid),
    .win_id      (win_id),
    .win_prio    (win_prio),
    .win_nmi     (win_nmi)
);

// File: tb/sim_nmi_irq_arbiter.sv
`timescale 1ns/1ps
module sim_nmi_irq_arbiter;

    localparam int N    = 32;
    localparam int ID_W = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    pend, en, nmi, grp;
    logic [7:0]      pr [N];
    logic [N*8-1:0]  prio_flat;
    logic            sec_dis;
    logic [7:0]      msg_prio;
    logic [ID_W-1:0] msg_id;
    logic            msg_lpi_en, msg_glb_en, msg_g1ns_en;
    logic            win_valid;
    logic [ID_W-1:0] win_id;
    logic [7:0]      win_prio;
    logic            win_nmi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = pr[i];
    end

    nmi_irq_arbiter #(.N(N), .ID_W(ID_W)) u0 (
        .clk(clk), .rst(rst), .pend(pend), .en(en), .nmi(nmi), .grp(grp),
        .prio_flat(prio_flat), .sec_dis(sec_dis), .msg_prio(msg_prio),
        .msg_id(msg_id), .msg_lpi_en(msg_lpi_en), .msg_glb_en(msg_glb_en),
        .msg_g1ns_en(msg_g1ns_en), .win_valid(win_valid), .win_id(win_id),
        .win_prio(win_prio), .win_nmi(win_nmi)
    );

    task automatic clear_all();
        pend = '0; en = '0; nmi = '0; grp = '0; sec_dis = 1'b0;
        for (int i = 0; i < N; i++) pr[i] = 8'hFF;
        msg_prio = 8'hFF; msg_id = '0;
        msg_lpi_en = 1'b0; msg_glb_en = 1'b0; msg_g1ns_en = 1'b0;
    endtask

    task automatic add_line(int i, logic [7:0] p, logic is_nmi, logic g);
        pend[i] = 1'b1; en[i] = 1'b1; pr[i] = p; nmi[i] = is_nmi; grp[i] = g;
    endtask

    task automatic set_msg(logic [7:0] p, logic [ID_W-1:0] id, logic a, logic b, logic c);
        msg_prio = p; msg_id = id; msg_lpi_en = a; msg_glb_en = b; msg_g1ns_en = c;
    endtask

    task automatic check_now(string tag, logic v, int id, logic [7:0] p, logic n);
        checks++;
        if (win_valid !== v || win_id !== ID_W'(id) || win_prio !== p || win_nmi !== n) begin
            errors++;
            $display("FAIL %s: got v=%0b id=%0d prio=%h nmi=%0b, expected v=%0b id=%0d prio=%h nmi=%0b",
                     tag, win_valid, win_id, win_prio, win_nmi, v, id, p, n);
        end
    endtask

    task automatic expect_res(string tag, logic v, int id, logic [7:0] p, logic n);
        @(posedge clk); #1;
        check_now(tag, v, id, p, n);
    endtask

    task automatic begin_case();
        @(negedge clk);
        clear_all();
    endtask

    task automatic t_reset();
        clear_all();
        repeat (3) @(posedge clk);
        #1 check_now("R8 reset", 1'b0, 0, 8'hFF, 1'b0);
        @(negedge clk) rst = 1'b0;
        begin_case();
        expect_res("R8 no candidate", 1'b0, 0, 8'hFF, 1'b0);
    endtask

    task automatic t_strict();
        begin_case();
        add_line(3, 8'h40, 0, 0); add_line(10, 8'h20, 0, 0); add_line(20, 8'h30, 0, 0);
        expect_res("R1 strict lower", 1'b1, 10, 8'h20, 1'b0);
        // latency: change just after the falling edge, old winner still shown
        @(negedge clk);
        add_line(5, 8'h10, 0, 0);
        #1 check_now("R8 before edge", 1'b1, 10, 8'h20, 1'b0);
        expect_res("R8 after edge", 1'b1, 5, 8'h10, 1'b0);
    endtask

    task automatic t_nmi_prio();
        begin_case();
        add_line(7, 8'hF0, 1, 1); add_line(2, 8'h81, 0, 0);
        expect_res("R2 ns nmi 0x80", 1'b1, 7, 8'h80, 1'b1);
        begin_case();
        add_line(7, 8'hF0, 1, 1); add_line(2, 8'h7F, 0, 0);
        expect_res("R2 ordinary beats 0x80", 1'b1, 2, 8'h7F, 1'b0);
        begin_case();
        add_line(7, 8'hF0, 1, 0);
        expect_res("R2 secure nmi 0x00", 1'b1, 7, 8'h00, 1'b1);
        begin_case();
        sec_dis = 1'b1;
        add_line(7, 8'hF0, 1, 1);
        expect_res("R2 sec_dis nmi 0x00", 1'b1, 7, 8'h00, 1'b1);
    endtask

    task automatic t_nmi_tie();
        begin_case();
        add_line(1, 8'h80, 0, 0); add_line(9, 8'h11, 1, 1);
        expect_res("R3 nmi wins tie 0x80", 1'b1, 9, 8'h80, 1'b1);
        begin_case();
        add_line(0, 8'h00, 0, 0); add_line(30, 8'h55, 1, 0);
        expect_res("R3 nmi wins tie 0x00", 1'b1, 30, 8'h00, 1'b1);
    endtask

    task automatic t_ord_tie();
        begin_case();
        add_line(25, 8'h55, 0, 0); add_line(4, 8'h55, 0, 1); add_line(12, 8'h55, 0, 0);
        expect_res("R4 lowest id", 1'b1, 4, 8'h55, 1'b0);
        begin_case();
        add_line(31, 8'h55, 0, 0); add_line(25, 8'h55, 0, 0);
        expect_res("R4 lowest id high end", 1'b1, 25, 8'h55, 1'b0);
    endtask

    task automatic t_nmi_nmi();
        begin_case();
        add_line(18, 8'h01, 1, 0); add_line(6, 8'h22, 1, 0); add_line(2, 8'h00, 0, 0);
        expect_res("R5 first nmi kept", 1'b1, 6, 8'h00, 1'b1);
    endtask

    task automatic t_masked();
        begin_case();
        add_line(3, 8'h00, 1, 0); en[3] = 1'b0;
        add_line(11, 8'h00, 1, 0); pend[11] = 1'b0;
        add_line(15, 8'h90, 0, 0);
        expect_res("R6 masked nmi skipped", 1'b1, 15, 8'h90, 1'b0);
        begin_case();
        add_line(3, 8'h00, 1, 0); en[3] = 1'b0;
        add_line(11, 8'h00, 1, 0); pend[11] = 1'b0;
        expect_res("R6 only masked lines", 1'b0, 0, 8'hFF, 1'b0);
    endtask

    task automatic t_msg();
        begin_case();
        set_msg(8'h10, 16'h2000, 1, 1, 1);
        expect_res("R7 msg alone", 1'b1, 16'h2000, 8'h10, 1'b0);
        begin_case();
        set_msg(8'h10, 16'h2000, 0, 1, 1);
        expect_res("R7 lpi_en clear", 1'b0, 0, 8'hFF, 1'b0);
        begin_case();
        set_msg(8'h10, 16'h2000, 1, 0, 1);
        expect_res("R7 glb_en clear", 1'b0, 0, 8'hFF, 1'b0);
        begin_case();
        set_msg(8'h10, 16'h2000, 1, 1, 0);
        expect_res("R7 g1ns_en clear", 1'b0, 0, 8'hFF, 1'b0);
        begin_case();
        set_msg(8'hFF, 16'h2000, 1, 1, 1);
        expect_res("R7 msg prio 0xFF", 1'b0, 0, 8'hFF, 1'b0);
        begin_case();
        set_msg(8'h10, 16'h2000, 1, 1, 1); add_line(5, 8'h10, 0, 0);
        expect_res("R7 tie local lower id", 1'b1, 5, 8'h10, 1'b0);
        begin_case();
        set_msg(8'h10, 16'h0003, 1, 1, 1); add_line(5, 8'h10, 0, 0);
        expect_res("R7 tie msg lower id", 1'b1, 3, 8'h10, 1'b0);
        begin_case();
        set_msg(8'h0F, 16'h2000, 1, 1, 1); add_line(5, 8'h10, 0, 0);
        expect_res("R7 msg strictly lower", 1'b1, 16'h2000, 8'h0F, 1'b0);
        begin_case();
        set_msg(8'h00, 16'h0001, 1, 1, 1); add_line(5, 8'h44, 1, 0);
        expect_res("R5 nmi kept vs msg", 1'b1, 5, 8'h00, 1'b1);
        begin_case();
        set_msg(8'h7F, 16'h2000, 1, 1, 1); add_line(5, 8'h44, 1, 1);
        expect_res("R7 msg beats ns nmi", 1'b1, 16'h2000, 8'h7F, 1'b0);
    endtask

    task automatic t_ff();
        begin_case();
        add_line(13, 8'hFF, 0, 0);
        expect_res("R9 lone 0xFF line", 1'b1, 13, 8'hFF, 1'b0);
        begin_case();
        expect_res("R8 back to idle", 1'b0, 0, 8'hFF, 1'b0);
    endtask

    initial begin
        t_reset();
        t_strict();
        t_nmi_prio();
        t_nmi_tie();
        t_ord_tie();
        t_nmi_nmi();
        t_masked();
        t_msg();
        t_ff();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule